// File: doc/BRIEF.md
# Many-Core Inter-Processor Interrupt Hub

This block gathers interrupt requests for a system of up to 64 cores (48 by default) and turns them into one notification pulse per core. Each core owns three 64-bit registers: a status word that latches requests, a mask word that keeps chosen status bits from notifying, and a clear word. A write to the clear word removes status bits and also ends the current interrupt. The low six status bits come from device wires. The bits above them carry inter-processor interrupt (IPI) lines.

Software raises an IPI through request registers, and these are indexed by line, not by target core. Writing a 1 to bit Y of request register X raises line X at core Y. A core that has an unmasked status bit and no interrupt in service gets a one-cycle pulse. A single global configuration bit chooses which of two local interrupt pins the pulse is meant for. Once a pulse is sent, the core counts as in service until it writes its clear word. If unmasked bits are still set after that write, a new pulse goes out at once.

All registers sit at 8-byte-aligned addresses on a 32-bit bus. A byte-enable pattern picks the half of the 64-bit word being accessed.

Top module: `ipi_irq_hub`

## Requirements
- R1: Address decoding uses byte-address bits [12:10] for the region (0 configuration, 1 status, 2 mask, 3 clear, 4 request) and bits [9:3] for the entry index, which is the core number or the line number. Byte enable 0x0F selects bits 31:0 of the 64-bit word and 0xF0 selects bits 63:32. Read data and the error flag are valid in the cycle after the request.
- R2: An access is rejected if its byte enable is anything other than 0x0F or 0xF0 (0xFF included) or if address bits [2:0] are not zero. A rejected access pulses bus_err in the next cycle, returns read data of zero and changes no register.
- R3: Writing 1 to bit Y of request register X sets status bit 6+X of core Y and nothing else. Cores 0..31 are in the lower half of the request word and cores 32..63 are in the upper half. Request and clear registers read as zero.
- R4: A rising edge on dev_irq[6*c+k] sets status bit k (k = 0..5) of core c. An input that stays high does not set the bit again after it has been cleared.
- R5: A status bit whose mask bit is 1 never causes a pulse, not even at end-of-interrupt. After reset every implemented mask bit is 1. The mask reads back as written.
- R6: A core that is not in service and has an unmasked status bit receives a one-cycle pulse on irq_valid[c] in the cycle after the edge that made the bit pending. Sending the pulse puts the core in service.
- R7: A core in service receives no further pulse, whatever new unmasked bits arrive.
- R8: A write to a core's clear register clears the status bits written as 1 in the selected half and ends the interrupt. If unmasked bits remain, a new pulse appears in the cycle right after the write. If none remain, the core leaves the in-service state.
- R9: If a device rising edge and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R10: Bit 0 of configuration entry 0 (lower half) drives lint_sel: 0 means local pin 0 and 1 means pin 1. Its reset value is 0. Every pulse issued after a rewrite carries the new value.
- R11: Status bits that are never cleared stay set and can be read back at any later time.
- R12: After reset all status bits are 0, and irq_valid, lint_sel, bus_err and bus_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address |
| bus_be | input | 8 | Byte enables of the 64-bit word |
| bus_wdata | input | 32 | Write data for the selected half |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Rejected access, one cycle after the request |
| dev_irq | input | NUM_CORES*6 | Device interrupt wires, six per core |
| irq_valid | output | NUM_CORES | One-cycle notification pulse per core |
| lint_sel | output | 1 | Local pin carrying the notifications |

## Verification
Two cases are hard to reach through the ports. The first is a device edge that lands on a bit in the very cycle a clear write removes that bit. The bench reaches it by raising the device wire on the same falling edge on which it drives the clear write, so both are sampled by one rising edge. It then reads the status back and also watches the re-fire that the remaining bit causes. The second case is the re-fire at end-of-interrupt. To reach it, the bench stacks two IPIs onto a core that is already in service and then clears only one of them. It captures irq_valid in the cycle the write completes, which shows the new pulse is immediate.

// File: rtl/irq_hub_pkg.sv
// Shared constants and types of the interrupt hub.
// Assumes 64-bit registers reached as two 32-bit halves.
package irq_hub_pkg;
    localparam int DEV_BITS = 6;             // device inputs per core, below the IPI bits
    localparam int HALF_W   = 32;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int IDX_W    = 7;             // entry index inside a region
    localparam int RGN_W    = 3;
    localparam int ALIGN_W  = 3;             // 8-byte alignment
    localparam int ADDR_W   = ALIGN_W + IDX_W + RGN_W;
    localparam logic [7:0] BE_LO = 8'h0F;
    localparam logic [7:0] BE_HI = 8'hF0;

    typedef enum logic [RGN_W-1:0] {
        RGN_CFG    = 3'd0,
        RGN_STATUS = 3'd1,
        RGN_MASK   = 3'd2,
        RGN_CLEAR  = 3'd3,
        RGN_REQ    = 3'd4
    } region_e;

    typedef struct packed {
        logic             hit;    // accepted access this cycle
        logic             write;
        logic             upper;  // 1: bits 63:32
        region_e          rgn;
        logic [IDX_W-1:0] idx;
    } acc_t;
endpackage

// File: rtl/irq_hub_decode.sv
// Bus decoder: splits an access into region, index and half.
// Rejects anything that is not an aligned 32-bit half access.
// Purely combinational; the caller registers the responses.
module irq_hub_decode
    import irq_hub_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_be,
    output acc_t              acc,
    output logic              reject
);
    logic be_ok;
    logic aligned;

    // Accept only the two half-word enable patterns on aligned addresses.
    always_comb begin
        be_ok     = (bus_be == BE_LO) || (bus_be == BE_HI);
        aligned   = (bus_addr[ALIGN_W-1:0] == '0);
        acc.hit   = bus_valid && be_ok && aligned;
        acc.write = bus_write;
        acc.upper = (bus_be == BE_HI);
        acc.rgn   = region_e'(bus_addr[ADDR_W-1 -: RGN_W]);
        acc.idx   = bus_addr[ALIGN_W +: IDX_W];
        reject    = bus_valid && !(be_ok && aligned);
    end
endmodule

// File: rtl/irq_hub_slice.sv
// One core's status, mask and in-service state plus its pulse.
// Assumes st_data/st_en already hold the written half at status
// bit positions and req_bit already holds this core's request bit.
module irq_hub_slice
    import irq_hub_pkg::*;
#(
    parameter int NUM_IPI = 16,
    parameter int CORE_ID = 0,
    parameter int STAT_W  = DEV_BITS + NUM_IPI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_t              acc,
    input  logic [STAT_W-1:0] st_data,
    input  logic [STAT_W-1:0] st_en,
    input  logic              req_bit,
    input  logic [DEV_BITS-1:0] dev_in,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CORE_ID);

    logic [DEV_BITS-1:0] dev_prev_q;
    logic [STAT_W-1:0]   status_q, mask_q, set_vec, clr_vec, status_nx;
    logic [NUM_IPI-1:0]  ipi_set;
    logic                wr_here, mask_wr, eoi, req_wr, fire;
    logic                in_service_q, irq_q;

    assign wr_here = acc.hit && acc.write && (acc.idx == MY_IDX);
    assign mask_wr = wr_here && (acc.rgn == RGN_MASK);
    assign eoi     = wr_here && (acc.rgn == RGN_CLEAR);
    assign req_wr  = acc.hit && acc.write && (acc.rgn == RGN_REQ) && req_bit;

    // Request register x addresses IPI line x of this core.
    for (genvar x = 0; x < NUM_IPI; x++) begin : g_line
        assign ipi_set[x] = req_wr && (acc.idx == IDX_W'(x));
    end

    // Sets win over clears; pulse when ready and something unmasked is left.
    always_comb begin
        set_vec   = {ipi_set, dev_in & ~dev_prev_q};
        clr_vec   = eoi ? st_data : '0;
        status_nx = (status_q & ~clr_vec) | set_vec;
        fire      = (!in_service_q || eoi) && (|(status_nx & ~mask_q));
    end

    // Remember device levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_prev_q <= '0;
        else        dev_prev_q <= dev_in;
    end

    // Latch requests and apply clears.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nx;
    end

    // Mask register, all masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= (mask_q & ~st_en) | st_data;
    end

    // In-service flag: set by a pulse, dropped by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)    in_service_q <= 1'b0;
        else if (fire) in_service_q <= 1'b1;
        else if (eoi)  in_service_q <= 1'b0;
    end

    // One-cycle notification pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign status_o = status_o_w;
    logic [STAT_W-1:0] status_o_w;
    assign status_o_w = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = irq_q;

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !eoi) |=> !irq_q);
    // R7
    in_service_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service_q && !eoi) |=> in_service_q);
    // R5
    masked_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (|(status_q & ~$past(mask_q))));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_hub_rdmux.sv
// Read multiplexer: picks the addressed 64-bit word and returns
// the requested half. Returns zero for writes, write-only regions
// and indexes beyond the implemented cores.
module irq_hub_rdmux
    import irq_hub_pkg::*;
#(
    parameter int NUM_CORES = 48,
    parameter int STAT_W    = 22
) (
    input  acc_t              acc,
    input  logic [STAT_W-1:0] status_all [NUM_CORES],
    input  logic [STAT_W-1:0] mask_all   [NUM_CORES],
    input  logic              lint_sel,
    output logic [HALF_W-1:0] rd_half
);
    localparam int CORE_IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [WORD_W-1:0] word;
    logic              core_ok;

    // Select the word, then the half.
    always_comb begin
        word    = '0;
        core_ok = (int'(acc.idx) < NUM_CORES);
        if (acc.hit && !acc.write) begin
            case (acc.rgn)
                RGN_CFG:    if (acc.idx == '0) word[0] = lint_sel;
                RGN_STATUS: if (core_ok) word[STAT_W-1:0] = status_all[acc.idx[CORE_IW-1:0]];
                RGN_MASK:   if (core_ok) word[STAT_W-1:0] = mask_all[acc.idx[CORE_IW-1:0]];
                default:    word = '0;
            endcase
        end
        rd_half = acc.upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    end
endmodule

// File: rtl/ipi_irq_hub.sv
// Top of the interrupt hub: bus decode, one slice per core, read mux
// and the global pin-select bit. Assumes NUM_CORES <= 64 and
// 6 + NUM_IPI <= 64.
module ipi_irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_CORES = 48,
    parameter int NUM_IPI   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [7:0]                    bus_be,
    input  logic [HALF_W-1:0]             bus_wdata,
    output logic [HALF_W-1:0]             bus_rdata,
    output logic                          bus_err,
    input  logic [NUM_CORES*DEV_BITS-1:0] dev_irq,
    output logic [NUM_CORES-1:0]          irq_valid,
    output logic                          lint_sel
);
    localparam int STAT_W = DEV_BITS + NUM_IPI;

    acc_t              acc;
    logic              reject;
    logic [STAT_W-1:0] st_data, st_en;
    logic [NUM_CORES-1:0] req_bit;
    logic [STAT_W-1:0] status_all [NUM_CORES];
    logic [STAT_W-1:0] mask_all   [NUM_CORES];
    logic [HALF_W-1:0] rd_half;
    logic              lint_q;

    irq_hub_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .acc       (acc),
        .reject    (reject)
    );

    // Place the written half at status bit positions.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        localparam bit B_HI = (b >= HALF_W);
        assign st_en[b]   = (acc.upper == B_HI);
        assign st_data[b] = st_en[b] & bus_wdata[b % HALF_W];
    end

    // One slice per core; request bit c lives in the half holding core c.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam bit C_HI = (c >= HALF_W);
        assign req_bit[c] = (acc.upper == C_HI) & bus_wdata[c % HALF_W];
        irq_hub_slice #(
            .NUM_IPI (NUM_IPI),
            .CORE_ID (c),
            .STAT_W  (STAT_W)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (acc),
            .st_data  (st_data),
            .st_en    (st_en),
            .req_bit  (req_bit[c]),
            .dev_in   (dev_irq[c*DEV_BITS +: DEV_BITS]),
            .status_o (status_all[c]),
            .mask_o   (mask_all[c]),
            .irq_o    (irq_valid[c])
        );
    end

    irq_hub_rdmux #(
        .NUM_CORES (NUM_CORES),
        .STAT_W    (STAT_W)
    ) u_rd (
        .acc        (acc),
        .status_all (status_all),
        .mask_all   (mask_all),
        .lint_sel   (lint_q),
        .rd_half    (rd_half)
    );

    // Global pin select, written through configuration entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lint_q <= 1'b0;
        else if (acc.hit && acc.write && acc.rgn == RGN_CFG && acc.idx == '0 && !acc.upper)
            lint_q <= bus_wdata[0];
    end

    // Register the bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_half;
            bus_err   <= reject;
        end
    end

    assign lint_sel = lint_q;

    // R2
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_be != BE_LO && bus_be != BE_HI)
        |=> (bus_err && bus_rdata == '0 && $stable(lint_sel)));
    // R3
    req_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[ADDR_W-1 -: RGN_W] == RGN_REQ)
        |=> (bus_rdata == '0));
    // R10
    lint_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_be == BE_LO && bus_addr == '0)
        |=> (lint_sel == $past(bus_wdata[0])));
endmodule

// File: tb/ipi_irq_hub_test.sv
`timescale 1ns/1ps
module ipi_irq_hub_test;
    localparam int NC = 48;
    localparam int NI = 16;
    localparam int RG_CFG = 0, RG_ST = 1, RG_MK = 2, RG_CL = 3, RG_RQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [12:0]   bus_addr = '0;
    logic [7:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [NC*6-1:0] dev_irq = '0;
    logic [NC-1:0] irq_valid;
    logic          lint_sel;

    int checks = 0;
    int errors = 0;
    int irq_cnt [NC];
    logic irq_lint [NC];
    bit done = 0;

    always #2 clk = ~clk;

    ipi_irq_hub #(.NUM_CORES(NC), .NUM_IPI(NI)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .dev_irq(dev_irq),
        .irq_valid(irq_valid), .lint_sel(lint_sel)
    );

    // Count pulses and record the pin they were sent on.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NC; c++) begin
                if (irq_valid[c]) begin
                    irq_cnt[c] = irq_cnt[c] + 1;
                    irq_lint[c] = lint_sel;
                end
            end
        end
    end

    function automatic logic [12:0] adr(input int rgn, input int idx);
        return 13'((rgn << 10) | (idx << 3));
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit wr, input int rgn, input int idx, input logic [7:0] be,
                          input logic [31:0] d, output logic [31:0] rd, output logic er,
                          output logic [NC-1:0] irq);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = adr(rgn, idx); bus_be = be; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; er = bus_err; irq = irq_valid;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic wr_reg(input int rgn, input int idx, input bit hi, input logic [31:0] d,
                          output logic [NC-1:0] irq);
        logic [31:0] rd; logic er;
        bus_op(1'b1, rgn, idx, hi ? 8'hF0 : 8'h0F, d, rd, er, irq);
    endtask

    task automatic rd_reg(input int rgn, input int idx, input bit hi, output logic [31:0] rd);
        logic er; logic [NC-1:0] irq;
        bus_op(1'b0, rgn, idx, hi ? 8'hF0 : 8'h0F, 32'h0, rd, er, irq);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic er; logic [NC-1:0] irq;
        chk("R12 irq_valid", 64'(irq_valid), 64'h0);
        chk("R12 lint_sel", 64'(lint_sel), 64'h0);
        chk("R12 bus_err", 64'(bus_err), 64'h0);
        chk("R12 bus_rdata", 64'(bus_rdata), 64'h0);
        rd_reg(RG_ST, 0, 1'b0, rd);
        chk("R12 status core0", 64'(rd), 64'h0);
        rd_reg(RG_MK, 0, 1'b0, rd);
        chk("R5 mask reset lower", 64'(rd), 64'h3F_FFFF);
        rd_reg(RG_MK, 0, 1'b1, rd);
        chk("R5 mask reset upper", 64'(rd), 64'h0);
        bus_op(1'b0, RG_CFG, 0, 8'h0F, 32'h0, rd, er, irq);
        chk("R1 valid half access no error", 64'(er), 64'h0);
    endtask

    task automatic t_self_ipi;
        logic [31:0] rd; logic [NC-1:0] irq;
        wr_reg(RG_MK, 3, 1'b0, 32'h0, irq);
        wr_reg(RG_RQ, 2, 1'b0, 32'h1 << 3, irq);
        chk("R6 pulse the cycle after request", 64'(irq[3]), 64'h1);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R3 line 2 at bit 8 of core 3", 64'(rd), 64'h100);
        rd_reg(RG_ST, 2, 1'b0, rd);
        chk("R3 core 2 untouched", 64'(rd), 64'h0);
        idle(3);
        chk("R6 one pulse to core 3", 64'(irq_cnt[3]), 64'd1);
        chk("R6 no pulse to core 2", 64'(irq_cnt[2]), 64'd0);
        rd_reg(RG_RQ, 2, 1'b0, rd);
        chk("R3 request reads zero", 64'(rd), 64'h0);
        wr_reg(RG_CL, 3, 1'b0, 32'h100, irq);
        chk("R8 no refire when empty", 64'(irq[3]), 64'h0);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R8 clear removes bit", 64'(rd), 64'h0);
    endtask

    task automatic t_cross;
        logic [31:0] rd; logic [NC-1:0] irq;
        wr_reg(RG_RQ, 5, 1'b1, 32'h1 << 8, irq);
        rd_reg(RG_ST, 40, 1'b0, rd);
        chk("R3 line 5 at bit 11 of core 40", 64'(rd), 64'h800);
        rd_reg(RG_ST, 5, 1'b0, rd);
        chk("R3 core 5 untouched", 64'(rd), 64'h0);
        idle(3);
        chk("R5 masked core 40 silent", 64'(irq_cnt[40]), 64'd0);
        wr_reg(RG_MK, 40, 1'b0, 32'h0, irq);
        idle(3);
        chk("R6 unmask then pulse", 64'(irq_cnt[40]), 64'd1);
        wr_reg(RG_CL, 40, 1'b0, 32'h800, irq);
        rd_reg(RG_ST, 40, 1'b0, rd);
        chk("R8 core 40 cleared", 64'(rd), 64'h0);
    endtask

    task automatic t_refire;
        logic [31:0] rd; logic [NC-1:0] irq; int base;
        base = irq_cnt[3];
        wr_reg(RG_RQ, 0, 1'b0, 32'h8, irq);
        chk("R6 first pulse", 64'(irq[3]), 64'h1);
        wr_reg(RG_RQ, 1, 1'b0, 32'h8, irq);
        chk("R7 no pulse in service", 64'(irq[3]), 64'h0);
        idle(3);
        chk("R7 count one", 64'(irq_cnt[3]), 64'(base + 1));
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R3 two lines pending", 64'(rd), 64'hC0);
        wr_reg(RG_CL, 3, 1'b0, 32'h40, irq);
        chk("R8 immediate refire", 64'(irq[3]), 64'h1);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R8 residual bit", 64'(rd), 64'h80);
        wr_reg(RG_CL, 3, 1'b0, 32'h80, irq);
        chk("R8 no refire after last", 64'(irq[3]), 64'h0);
        idle(3);
        chk("R8 count two", 64'(irq_cnt[3]), 64'(base + 2));
        wr_reg(RG_RQ, 3, 1'b0, 32'h8, irq);
        chk("R8 in-service released", 64'(irq[3]), 64'h1);
        wr_reg(RG_CL, 3, 1'b0, 32'h200, irq);
    endtask

    task automatic t_mask_hold;
        logic [31:0] rd; logic [NC-1:0] irq;
        wr_reg(RG_MK, 3, 1'b0, 32'h400, irq);
        wr_reg(RG_RQ, 4, 1'b0, 32'h8, irq);
        chk("R5 masked request silent", 64'(irq[3]), 64'h0);
        wr_reg(RG_CL, 3, 1'b0, 32'h0, irq);
        chk("R5 masked residual no refire", 64'(irq[3]), 64'h0);
        idle(20);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R11 unacknowledged bit held", 64'(rd), 64'h400);
        rd_reg(RG_MK, 3, 1'b0, rd);
        chk("R5 mask readback", 64'(rd), 64'h400);
        wr_reg(RG_CL, 3, 1'b0, 32'h400, irq);
        wr_reg(RG_MK, 3, 1'b0, 32'h0, irq);
    endtask

    task automatic t_dev;
        logic [31:0] rd; logic [NC-1:0] irq; int base;
        base = irq_cnt[3];
        @(negedge clk); dev_irq[3*6+2] = 1'b1;
        idle(3);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R4 device edge sets bit 2", 64'(rd), 64'h4);
        chk("R4 device pulse", 64'(irq_cnt[3]), 64'(base + 1));
        wr_reg(RG_CL, 3, 1'b0, 32'h4, irq);
        idle(3);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R4 steady level does not reset bit", 64'(rd), 64'h0);
        @(negedge clk);
        dev_irq[3*6+1] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(RG_CL, 3); bus_be = 8'h0F; bus_wdata = 32'h2;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R9 set beats clear", 64'(rd), 64'h2);
        dev_irq[3*6+1] = 1'b0; dev_irq[3*6+2] = 1'b0;
        wr_reg(RG_CL, 3, 1'b0, 32'h2, irq);
        idle(2);
    endtask

    task automatic t_lint;
        logic [31:0] rd; logic [NC-1:0] irq;
        wr_reg(RG_CFG, 0, 1'b0, 32'h1, irq);
        rd_reg(RG_CFG, 0, 1'b0, rd);
        chk("R10 config readback", 64'(rd), 64'h1);
        chk("R10 lint_sel follows", 64'(lint_sel), 64'h1);
        wr_reg(RG_RQ, 0, 1'b0, 32'h8, irq);
        idle(3);
        chk("R10 pulse on pin 1", 64'(irq_lint[3]), 64'h1);
        wr_reg(RG_CL, 3, 1'b0, 32'h40, irq);
        wr_reg(RG_CFG, 0, 1'b0, 32'h0, irq);
        wr_reg(RG_RQ, 0, 1'b0, 32'h8, irq);
        idle(3);
        chk("R10 pulse back on pin 0", 64'(irq_lint[3]), 64'h0);
        wr_reg(RG_CL, 3, 1'b0, 32'h40, irq);
    endtask

    task automatic t_reject;
        logic [31:0] rd; logic er; logic [NC-1:0] irq;
        bus_op(1'b1, RG_MK, 3, 8'hFF, 32'hFFFF_FFFF, rd, er, irq);
        chk("R2 64-bit write flagged", 64'(er), 64'h1);
        rd_reg(RG_MK, 3, 1'b0, rd);
        chk("R2 mask unchanged", 64'(rd), 64'h0);
        bus_op(1'b0, RG_MK, 0, 8'hFF, 32'h0, rd, er, irq);
        chk("R2 64-bit read flagged", 64'(er), 64'h1);
        chk("R2 64-bit read data zero", 64'(rd), 64'h0);
        bus_op(1'b1, RG_RQ, 0, 8'hFF, 32'h8, rd, er, irq);
        chk("R2 rejected request no pulse", 64'(irq[3]), 64'h0);
        rd_reg(RG_ST, 3, 1'b0, rd);
        chk("R2 rejected request no status", 64'(rd), 64'h0);
        bus_op(1'b1, RG_CFG, 0, 8'h03, 32'h1, rd, er, irq);
        chk("R2 partial enable flagged", 64'(er), 64'h1);
        chk("R2 lint_sel unchanged", 64'(lint_sel), 64'h0);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin irq_cnt[c] = 0; irq_lint[c] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_self_ipi();
        t_cross();
        t_refire();
        t_mask_hold();
        t_dev();
        t_lint();
        t_reject();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule